// File: doc/BRIEF.md
# Burst Pulse Pattern Generator

This block generates the four logic-level drive lines of a four-channel high-voltage ultrasound-style pulser: a positive-pulse request, a negative-pulse request, an output enable and a clamp request. It runs from a fixed system clock (66 MHz by default). While the run input is high it starts a new burst by itself at every frame boundary; a frame lasts `FRAME_CLKS` clocks, which is 50 µs at 66 MHz. A burst is a train of pulses clocked by a selectable burst clock. Each pulse is four equal slots: first polarity, gap, second polarity, gap.

Five pattern types are offered. Two are non-return-to-zero types in which the enable covers the whole burst. Two are return-to-zero types in which the clamp is driven during the gaps. One continuous type repeats the slot cycle without end, and in that type the enable is gated by a slow low-duty envelope. Pattern, rate and pulse count are sampled only at frame boundaries, so the selections may change at any time without cutting a burst short.

Top module: `burst_pulse_gen`

## Requirements
- R1: While `run` is low, and during reset, all four outputs are low. After the first clock edge that samples `run` low, the outputs are low from that edge on.
- R2: While running, a frame starts at the first clock edge that samples `run` high, and then again every `FRAME_CLKS` edges. Each frame starts a fresh burst whose first slot begins right after that edge.
- R3: `countSel` value k yields k+1 pulses per frame (1 to 4) in the burst patterns.
- R4: Every slot lasts D clocks. D is picked by `rateSel` index 0..7 as 132, 66, 26, 12, 8, 6, 4, 2 (0.5, 1, 2.54, 5.5, 8.25, 11, 16.5, 33 MHz at 66 MHz).
- R5: The `patSel` codes are 0 = NRZ positive first, 1 = NRZ negative first, 2 = RZ positive first, 3 = RZ negative first, 4 = continuous. In every pulse, slot 0 carries the first polarity, slot 2 carries the other polarity, and slots 1 and 3 drive neither polarity.
- R6: In codes 0 and 1, `drvEn` is high for exactly the whole burst and `drvClamp` stays low.
- R7: In codes 2 and 3, `drvEn` is high for the whole burst and `drvClamp` is high in the gap slots inside the burst only. `drvClamp` is never high together with a polarity output.
- R8: In code 4, the four-slot cycle repeats until the next frame boundary, where it restarts at slot 0, and `drvClamp` stays low. `drvEn` is high while the envelope count (edges since `run` rose, modulo `ENV_PERIOD`) is below `ENV_ON`.
- R9: `drvP` and `drvN` are never high in the same cycle.
- R10: Changes on `patSel`, `rateSel` and `countSel` in the middle of a frame do not affect that frame. They take effect at the next frame boundary.
- R11: Codes 5 to 7 are reserved. A frame that samples one of them keeps all four outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| run | input | 1 | High to run, low to stop |
| patSel | input | 3 | Pattern code (R5, R11) |
| rateSel | input | 3 | Burst clock index (R4) |
| countSel | input | CNT_W | Pulses per frame minus one |
| drvP | output | 1 | Positive pulse request |
| drvN | output | 1 | Negative pulse request |
| drvEn | output | 1 | Output stage enable |
| drvClamp | output | 1 | Clamp request |

## Verification
The bench goes after the slowest rate combined with four pulses, where a burst whose end is counted wrongly spills into the gap before the next frame or stops one pulse early. It changes the selections in the middle of a frame; a design that samples them continuously would switch polarity order or slot width mid-burst. It stops and restarts in the middle of frames, which shows a divider or slot counter that is not cleared by a shifted slot phase. It runs the continuous pattern across several frame boundaries and envelope periods, so an envelope that is off by one edge, or a continuous pattern that ends after the pulse count, shows as an enable or polarity mismatch against the bench's own slot model.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

  localparam int DIV_W = 8;

  typedef struct packed {
    logic frameStart;
    logic tick;
    logic envOn;
  } strobe_t;

  typedef enum logic [2:0] {
    PAT_NRZ_P = 3'd0,
    PAT_NRZ_N = 3'd1,
    PAT_RZ_P  = 3'd2,
    PAT_RZ_N  = 3'd3,
    PAT_CW    = 3'd4
  } pat_e;

  function automatic logic [DIV_W-1:0] rateDiv(input logic [2:0] idx);
    case (idx)
      3'd0: rateDiv = 8'd132;
      3'd1: rateDiv = 8'd66;
      3'd2: rateDiv = 8'd26;
      3'd3: rateDiv = 8'd12;
      3'd4: rateDiv = 8'd8;
      3'd5: rateDiv = 8'd6;
      3'd6: rateDiv = 8'd4;
      default: rateDiv = 8'd2;
    endcase
  endfunction

endpackage

// File: rtl/bpg_ctrl.sv
module bpg_ctrl
  import bpg_pkg::*;
#(
  parameter int FRAME_CLKS = 3300,
  parameter int ENV_PERIOD = 6600000,
  parameter int ENV_ON     = 660000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic [2:0] rateSel,
  output strobe_t    strb
);

  localparam int FW = $clog2(FRAME_CLKS);
  localparam int EW = $clog2(ENV_PERIOD);
  localparam logic [FW-1:0] FRAME_LAST = FW'(FRAME_CLKS - 1);
  localparam logic [EW-1:0] ENV_LAST   = EW'(ENV_PERIOD - 1);
  localparam logic [EW-1:0] ENV_HIGH   = EW'(ENV_ON);

  logic [FW-1:0]    frameCnt;
  logic [EW-1:0]    envCnt;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLen;
  logic [2:0]       rateLat;
  logic             frameStart;
  logic             divWrap;

  assign frameStart = run && (frameCnt == '0);
  assign divLen     = rateDiv(rateLat);
  assign divWrap    = (divCnt == divLen - 8'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt <= '0;
      envCnt   <= '0;
    end else if (!run) begin
      frameCnt <= '0;
      envCnt   <= '0;
    end else begin
      frameCnt <= (frameCnt == FRAME_LAST) ? '0 : frameCnt + 1'b1;
      envCnt   <= (envCnt == ENV_LAST) ? '0 : envCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateLat <= '0;
      divCnt  <= '0;
    end else if (!run) begin
      divCnt  <= '0;
    end else if (frameStart) begin
      rateLat <= rateSel;
      divCnt  <= '0;
    end else begin
      divCnt  <= divWrap ? '0 : divCnt + 1'b1;
    end
  end

  assign strb.frameStart = frameStart;
  assign strb.tick       = run && !frameStart && divWrap;
  assign strb.envOn      = (envCnt < ENV_HIGH);

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    divCnt < divLen); // R4
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (run && frameCnt == FRAME_LAST) |=> (!run || frameStart)); // R2
  AST_RATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(rateLat)); // R10

endmodule

// File: rtl/bpg_shaper.sv
module bpg_shaper
  import bpg_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  strobe_t          strb,
  input  logic [2:0]       patSel,
  input  logic [CNT_W-1:0] countSel,
  output logic             drvP,
  output logic             drvN,
  output logic             drvEn,
  output logic             drvClamp
);

  logic [2:0]       patLat;
  logic [CNT_W-1:0] cntLat;
  logic [CNT_W-1:0] pulseIdx;
  logic [1:0]       slot;
  logic             active;
  logic             isCw;
  logic             isRz;
  logic             posFirst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      patLat   <= '0;
      cntLat   <= '0;
      pulseIdx <= '0;
      slot     <= '0;
      active   <= 1'b0;
    end else if (!run) begin
      pulseIdx <= '0;
      slot     <= '0;
      active   <= 1'b0;
    end else if (strb.frameStart) begin
      patLat   <= patSel;
      cntLat   <= countSel;
      pulseIdx <= '0;
      slot     <= '0;
      active   <= (patSel <= 3'(PAT_CW));
    end else if (strb.tick && active) begin
      slot <= slot + 2'd1;
      if (slot == 2'd3) begin
        pulseIdx <= pulseIdx + 1'b1;
        if (pulseIdx == cntLat && !isCw) active <= 1'b0;
      end
    end
  end

  assign isCw     = (patLat == 3'(PAT_CW));
  assign isRz     = (patLat == 3'(PAT_RZ_P)) || (patLat == 3'(PAT_RZ_N));
  assign posFirst = (patLat == 3'(PAT_NRZ_P)) || (patLat == 3'(PAT_RZ_P)) || isCw;

  assign drvP     = active && ((slot == 2'd0 && posFirst) || (slot == 2'd2 && !posFirst));
  assign drvN     = active && ((slot == 2'd0 && !posFirst) || (slot == 2'd2 && posFirst));
  assign drvEn    = active && (isCw ? strb.envOn : 1'b1);
  assign drvClamp = active && isRz && slot[0];

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(drvP && drvN)); // R9
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> !(drvP || drvN || drvEn || drvClamp)); // R1
  AST_CLAMP_GAP: assert property (@(posedge clk) disable iff (!rstN)
    drvClamp |-> (!drvP && !drvN && drvEn)); // R7
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.frameStart |=> ($stable(patLat) && $stable(cntLat))); // R10
  AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (patLat > 3'(PAT_CW)) |-> !(drvP || drvN || drvEn || drvClamp)); // R11

endmodule

// File: rtl/burst_pulse_gen.sv
module burst_pulse_gen
  import bpg_pkg::*;
#(
  parameter int FRAME_CLKS = 3300,
  parameter int ENV_PERIOD = 6600000,
  parameter int ENV_ON     = 660000,
  parameter int CNT_W      = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [2:0]       patSel,
  input  logic [2:0]       rateSel,
  input  logic [CNT_W-1:0] countSel,
  output logic             drvP,
  output logic             drvN,
  output logic             drvEn,
  output logic             drvClamp
);

  strobe_t strb;

  bpg_ctrl #(
    .FRAME_CLKS(FRAME_CLKS),
    .ENV_PERIOD(ENV_PERIOD),
    .ENV_ON(ENV_ON)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .run(run),
    .rateSel(rateSel),
    .strb(strb)
  );

  bpg_shaper #(
    .CNT_W(CNT_W)
  ) u_shaper (
    .clk(clk),
    .rstN(rstN),
    .run(run),
    .strb(strb),
    .patSel(patSel),
    .countSel(countSel),
    .drvP(drvP),
    .drvN(drvN),
    .drvEn(drvEn),
    .drvClamp(drvClamp)
  );

endmodule

// File: tb/burst_pulse_gen_test.sv
module burst_pulse_gen_test;

  localparam int FRAME = 3300;
  localparam int ENVP  = 1000;
  localparam int ENVON = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic run = 1'b0;
  logic [2:0] patSel = '0;
  logic [2:0] rateSel = '0;
  logic [1:0] countSel = '0;
  logic drvP, drvN, drvEn, drvClamp;

  always #5 clk = ~clk;

  burst_pulse_gen #(.FRAME_CLKS(FRAME), .ENV_PERIOD(ENVP), .ENV_ON(ENVON), .CNT_W(2)) uut (
    .clk(clk), .rstN(rstN), .run(run), .patSel(patSel), .rateSel(rateSel),
    .countSel(countSel), .drvP(drvP), .drvN(drvN), .drvEn(drvEn), .drvClamp(drvClamp)
  );

  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;
  bit chk = 1'b0;

  // bench model state
  int m = 0;
  logic [2:0] ePat = '0;
  logic [1:0] eCnt = '0;
  int eD = 132;

  function automatic int divOf(input logic [2:0] r);
    int t[8] = '{132, 66, 26, 12, 8, 6, 4, 2};
    return t[r];
  endfunction

  always @(posedge clk) begin
    if (rstN && run) begin
      if (m % FRAME == 0) begin
        ePat = patSel;
        eCnt = countSel;
        eD   = divOf(rateSel);
      end
      m = m + 1;
    end else begin
      m = 0;
    end
  end

  // expected {drvP, drvN, drvEn, drvClamp}
  function automatic logic [3:0] expectVec();
    int p, s, sl;
    logic act, fp, ep, en, ec;
    if (m == 0 || ePat > 3'd4) return 4'b0000;
    p  = (m - 1) % FRAME;
    s  = p / eD;
    sl = s % 4;
    if (ePat == 3'd4) return {sl == 0, sl == 2, (m % ENVP) < ENVON, 1'b0};
    act = (s < 4 * (int'(eCnt) + 1));
    fp  = (ePat == 3'd0) || (ePat == 3'd2);
    ep  = act && ((sl == 0 && fp) || (sl == 2 && !fp));
    en  = act && ((sl == 0 && !fp) || (sl == 2 && fp));
    ec  = act && (ePat == 3'd2 || ePat == 3'd3) && (sl % 2 == 1);
    return {ep, en, act, ec};
  endfunction

  function automatic string tagOf(input logic [3:0] a, input logic [3:0] e);
    if (m == 0) return "R1";
    if (ePat > 3'd4) return "R11";
    if (a[3] && a[2]) return "R9";
    if (ePat == 3'd4) return "R8";
    if (a[0] != e[0]) return "R7";
    if (a[1] != e[1]) return "R6";
    return "R5";
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (chk && rstN) begin
      logic [3:0] a, e;
      a = {drvP, drvN, drvEn, drvClamp};
      e = expectVec();
      check(a == e, tagOf(a, e), int'(a), int'(e));
    end
  end

  task automatic startCfg(input logic [2:0] p, input logic [1:0] c, input logic [2:0] r);
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    patSel = p;
    countSel = c;
    rateSel = r;
    run = 1'b1;
  endtask

  initial begin
    int rises, highs, first, second;
    logic prevP;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    check({drvP, drvN, drvEn, drvClamp} == 4'b0, "R1", int'({drvP, drvN, drvEn, drvClamp}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check({drvP, drvN, drvEn, drvClamp} == 4'b0, "R1", int'({drvP, drvN, drvEn, drvClamp}), 0);
    chk = 1'b1;

    // R3: three pulses at fastest rate within one frame
    startCfg(3'd0, 2'd2, 3'd7);
    rises = 0; prevP = 1'b0;
    for (int i = 0; i < FRAME; i++) begin
      @(negedge clk);
      if (drvP && !prevP) rises++;
      prevP = drvP;
    end
    check(rises == 3, "R3", rises, 3);

    // R4: slot width 12 clocks, one pulse
    startCfg(3'd0, 2'd0, 3'd3);
    highs = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (drvP) highs++;
    end
    check(highs == 12, "R4", highs, 12);

    // R4: slowest slot width on the negative-first pattern
    startCfg(3'd1, 2'd0, 3'd0);
    highs = 0;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if (drvN) highs++;
    end
    check(highs == 132, "R4", highs, 132);

    // R2: bursts FRAME clocks apart
    startCfg(3'd0, 2'd0, 3'd7);
    first = -1; second = -1; prevP = 1'b0;
    for (int i = 0; i < 2 * FRAME; i++) begin
      @(negedge clk);
      if (drvP && !prevP) begin
        if (first < 0) first = i; else if (second < 0) second = i;
      end
      prevP = drvP;
    end
    check(first == 0, "R2", first, 0);
    check(second - first == FRAME, "R2", second - first, FRAME);

    // R10: mid-frame pattern change is deferred
    startCfg(3'd0, 2'd3, 3'd0);
    for (int i = 0; i < FRAME; i++) begin
      @(negedge clk);
      if (i == 50) patSel = 3'd1;
      if (i == 100) check(drvP == 1'b1, "R10", int'(drvP), 1);
    end
    @(negedge clk);
    check(drvN == 1'b1 && drvP == 1'b0, "R10", int'({drvP, drvN}), 1);

    // R1: stop takes effect after one edge
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check({drvP, drvN, drvEn, drvClamp} == 4'b0, "R1", int'({drvP, drvN, drvEn, drvClamp}), 0);

    // directed RZ and continuous segments (model-checked: R7, R8)
    startCfg(3'd3, 2'd3, 3'd0);
    repeat (FRAME) @(negedge clk);
    startCfg(3'd4, 2'd0, 3'd5);
    repeat (2 * FRAME + 500) @(negedge clk);

    // constrained random segments
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      patSel   = 3'($urandom_range(0, 7));
      countSel = 2'($urandom_range(0, 3));
      rateSel  = 3'($urandom_range(0, 7));
      run      = ($urandom_range(0, 99) < 85);
      repeat ($urandom_range(500, 5000)) @(negedge clk);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
      $finish;
    end
  end

endmodule